// File: doc/BRIEF.md
# Coprocessor Issue Front End with Length and Accept Tokens

This block is the front end of a coprocessor that runs decoupled from a host core. Decoded instructions arrive with a tag, a vectored-transfer flag and a transfer count, and wait in a small in-order queue. The oldest entry moves into a single issue register. As it moves, the block presents a length token to the core. The token carries the transfer count and the entry's tag.

While an instruction sits in issue, the coprocessor decides whether it can take the instruction. When the instruction leaves issue for the first execute stage, the block presents an accept token to the core. That token carries the decision and the tag. A refused instruction is not dropped. It moves on into the first execute stage marked as a phantom. Each token has an active-high hold line, which is low only in the cycle the token is valid.

The issue stage advances only when the execute stage signals ready. The queue refills the issue register in the same cycle the issue register empties, so an instruction can enter issue on every cycle.

Top module: `cp_issue_front`

## Requirements
- R1: During and right after reset: q_empty=1, q_full=0, len_hold=1, acc_hold=1 and ex_valid=0.
- R2: Instructions leave the queue in push order. The tags on successive length tokens follow the order of the accepted pushes.
- R3: q_full is 1 exactly when the queue holds DEPTH entries. A push in a cycle where q_full is 1 is ignored, and that entry never produces a token.
- R4: In a cycle where the head entry moves into issue, len_hold is 0 and len_tag equals that entry's tag.
- R5: len_val equals the pushed length when the vectored flag is 1, and is 0 when the vectored flag is 0.
- R6: len_hold is 1 in every cycle where no instruction enters issue. This includes a cycle with an empty queue.
- R7: In a cycle where the issue stage hands its instruction on, acc_hold is 0, acc_tag equals the issue tag and acc_flag equals can_accept in that cycle.
- R8: acc_hold goes low on every handoff, whether the instruction is accepted or refused. It is 1 in all other cycles.
- R9: While ex_ready is 0 and issue is occupied, the issue instruction stays put, and neither an accept token nor a length token is produced.
- R10: One cycle after a handoff, ex_valid=1, ex_tag and ex_opcode are those of the handed-on instruction, and ex_phantom equals the inverse of the accept flag. Refused instructions still appear there.
- R11: When issue is occupied and ex_ready is 1, a non-empty queue moves its head into issue in the same cycle, giving back-to-back tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push a decoded instruction into the queue |
| push_opcode | input | OPC_W | Decoded opcode |
| push_vec | input | 1 | 1 = vectored data transfer |
| push_len | input | LEN_W | Transfer count for a vectored transfer |
| push_tag | input | TAG_W | Instruction tag |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| can_accept | input | 1 | Accept decision for the instruction in issue |
| ex_ready | input | 1 | First execute stage can take an instruction |
| len_hold | output | 1 | Low when a length token is valid |
| len_val | output | LEN_W | Length token transfer count |
| len_tag | output | TAG_W | Length token tag |
| acc_hold | output | 1 | Low when an accept token is valid |
| acc_flag | output | 1 | Accept token decision |
| acc_tag | output | TAG_W | Accept token tag |
| ex_valid | output | 1 | First execute stage holds an instruction |
| ex_opcode | output | OPC_W | Opcode in the first execute stage |
| ex_tag | output | TAG_W | Tag in the first execute stage |
| ex_phantom | output | 1 | Instruction in the first execute stage was refused |

## Verification
The bench builds the block with its defaults: a four-entry queue and 4-bit tags, 4-bit lengths and 8-bit opcodes. The shallow queue fills within a few cycles of stalling, so overflowing pushes and the full flag are exercised many times. With random stalls, the pushes, occupied-issue stalls, back-to-back refills and refused instructions all overlap. Four-bit tags wrap quickly, which gives a tag mix-up no chance to hide behind unique values.

// File: rtl/cpif_pkg.sv
package cpif_pkg;
  // Circular pointer advance for a ring of depth entries.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Transfer count carried on the length token: zero for non-vectored.
  function automatic int unsigned token_len(bit vec, int unsigned len);
    return vec ? len : 0;
  endfunction
endpackage

// File: rtl/cpif_queue.sv
module cpif_queue #(
  parameter int OPC_W = 8,
  parameter int LEN_W = 4,
  parameter int TAG_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [OPC_W-1:0] in_opc,
  input  logic             in_vec,
  input  logic [LEN_W-1:0] in_len,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             pop,
  output logic [OPC_W-1:0] hd_opc,
  output logic             hd_vec,
  output logic [LEN_W-1:0] hd_len,
  output logic [TAG_W-1:0] hd_tag,
  output logic             full,
  output logic             empty
);
  import cpif_pkg::*;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [OPC_W-1:0] opc_m [DEPTH];
  logic             vec_m [DEPTH];
  logic [LEN_W-1:0] len_m [DEPTH];
  logic [TAG_W-1:0] tag_m [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok;
  logic             pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && wr_ptr == PTR_W'(g)) begin
        opc_m[g] <= in_opc;
        vec_m[g] <= in_vec;
        len_m[g] <= in_len;
        tag_m[g] <= in_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign hd_opc = opc_m[rd_ptr];
  assign hd_vec = vec_m[rd_ptr];
  assign hd_len = len_m[rd_ptr];
  assign hd_tag = tag_m[rd_ptr];

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count))
    else $error("push into full queue changed occupancy");

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH))
    else $error("occupancy above depth");
endmodule

// File: rtl/cpif_issue.sv
module cpif_issue #(
  parameter int OPC_W = 8,
  parameter int LEN_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [OPC_W-1:0] hd_opc,
  input  logic             hd_vec,
  input  logic [LEN_W-1:0] hd_len,
  input  logic [TAG_W-1:0] hd_tag,
  input  logic             can_accept,
  input  logic             ex_ready,
  output logic             pop,
  output logic             len_hold,
  output logic [LEN_W-1:0] len_val,
  output logic [TAG_W-1:0] len_tag,
  output logic             acc_hold,
  output logic             acc_flag,
  output logic [TAG_W-1:0] acc_tag,
  output logic             hand_off,
  output logic [OPC_W-1:0] iss_opc_o,
  output logic [TAG_W-1:0] iss_tag_o
);
  import cpif_pkg::*;

  logic             iss_valid;
  logic [OPC_W-1:0] iss_opc;
  logic [TAG_W-1:0] iss_tag;
  logic             enter_issue;

  assign hand_off    = iss_valid && ex_ready;
  assign enter_issue = !q_empty && (!iss_valid || ex_ready);
  assign pop         = enter_issue;

  assign len_hold = !enter_issue;
  assign len_val  = LEN_W'(token_len(hd_vec, int'(hd_len)));
  assign len_tag  = hd_tag;

  assign acc_hold = !hand_off;
  assign acc_flag = can_accept;
  assign acc_tag  = iss_tag;

  assign iss_opc_o = iss_opc;
  assign iss_tag_o = iss_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_opc   <= '0;
      iss_tag   <= '0;
    end else if (enter_issue) begin
      iss_valid <= 1'b1;
      iss_opc   <= hd_opc;
      iss_tag   <= hd_tag;
    end else if (hand_off) begin
      iss_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !ex_ready) |=> (iss_valid && $stable(iss_tag)))
    else $error("issue content moved during stall");

  // R4
  len_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_hold |-> !q_empty)
    else $error("length token with empty queue");

  // R8
  acc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hold |=> ($past(iss_valid) && $past(ex_ready)))
    else $error("accept token without a handoff");
endmodule

// File: rtl/cpif_exreg.sv
module cpif_exreg #(
  parameter int OPC_W = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             accept_in,
  input  logic [OPC_W-1:0] opc_in,
  input  logic [TAG_W-1:0] tag_in,
  output logic             ex_valid,
  output logic [OPC_W-1:0] ex_opcode,
  output logic [TAG_W-1:0] ex_tag,
  output logic             ex_phantom
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid   <= 1'b0;
      ex_opcode  <= '0;
      ex_tag     <= '0;
      ex_phantom <= 1'b0;
    end else begin
      ex_valid <= take;
      if (take) begin
        ex_opcode  <= opc_in;
        ex_tag     <= tag_in;
        ex_phantom <= !accept_in;
      end
    end
  end

  // R10
  phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ex_valid && ex_phantom == !$past(accept_in) && ex_tag == $past(tag_in)))
    else $error("execute stage entry mismatch");
endmodule

// File: rtl/cp_issue_front.sv
module cp_issue_front #(
  parameter int OPC_W = 8,
  parameter int LEN_W = 4,
  parameter int TAG_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [OPC_W-1:0] push_opcode,
  input  logic             push_vec,
  input  logic [LEN_W-1:0] push_len,
  input  logic [TAG_W-1:0] push_tag,
  output logic             q_full,
  output logic             q_empty,
  input  logic             can_accept,
  input  logic             ex_ready,
  output logic             len_hold,
  output logic [LEN_W-1:0] len_val,
  output logic [TAG_W-1:0] len_tag,
  output logic             acc_hold,
  output logic             acc_flag,
  output logic [TAG_W-1:0] acc_tag,
  output logic             ex_valid,
  output logic [OPC_W-1:0] ex_opcode,
  output logic [TAG_W-1:0] ex_tag,
  output logic             ex_phantom
);
  logic [OPC_W-1:0] hd_opc;
  logic             hd_vec;
  logic [LEN_W-1:0] hd_len;
  logic [TAG_W-1:0] hd_tag;
  logic             pop;
  logic             hand_off;
  logic [OPC_W-1:0] iss_opc;
  logic [TAG_W-1:0] iss_tag;

  cpif_queue #(.OPC_W(OPC_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .in_opc(push_opcode),
    .in_vec(push_vec), .in_len(push_len), .in_tag(push_tag), .pop(pop),
    .hd_opc(hd_opc), .hd_vec(hd_vec), .hd_len(hd_len), .hd_tag(hd_tag),
    .full(q_full), .empty(q_empty)
  );

  cpif_issue #(.OPC_W(OPC_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .hd_opc(hd_opc),
    .hd_vec(hd_vec), .hd_len(hd_len), .hd_tag(hd_tag),
    .can_accept(can_accept), .ex_ready(ex_ready), .pop(pop),
    .len_hold(len_hold), .len_val(len_val), .len_tag(len_tag),
    .acc_hold(acc_hold), .acc_flag(acc_flag), .acc_tag(acc_tag),
    .hand_off(hand_off), .iss_opc_o(iss_opc), .iss_tag_o(iss_tag)
  );

  cpif_exreg #(.OPC_W(OPC_W), .TAG_W(TAG_W)) u_ex (
    .clk(clk), .rst_n(rst_n), .take(hand_off), .accept_in(acc_flag),
    .opc_in(iss_opc), .tag_in(iss_tag), .ex_valid(ex_valid),
    .ex_opcode(ex_opcode), .ex_tag(ex_tag), .ex_phantom(ex_phantom)
  );

  // R11
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hand_off && !q_empty) |-> !len_hold)
    else $error("issue not refilled on handoff");
endmodule

// File: tb/cp_issue_front_tb.sv
`timescale 1ns/1ps
module cp_issue_front_tb;
  localparam int OPC_W = 8, LEN_W = 4, TAG_W = 4, DEPTH = 4;
  localparam int N_RAND = 4000;

  typedef struct {
    logic [OPC_W-1:0] opc;
    logic             vec;
    logic [LEN_W-1:0] len;
    logic [TAG_W-1:0] tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, push_vec = 1'b0, can_accept = 1'b0, ex_ready = 1'b0;
  logic [OPC_W-1:0] push_opcode = '0;
  logic [LEN_W-1:0] push_len = '0;
  logic [TAG_W-1:0] push_tag = '0;
  logic q_full, q_empty, len_hold, acc_hold, acc_flag, ex_valid, ex_phantom;
  logic [LEN_W-1:0] len_val;
  logic [TAG_W-1:0] len_tag, acc_tag, ex_tag;
  logic [OPC_W-1:0] ex_opcode;

  int checks = 0, errors = 0, ignored = 0, phantoms = 0;
  bit done = 0;

  item_t mq[$];
  item_t m_iss, m_ex;
  bit m_iss_v = 0, m_ex_v = 0, m_ex_ph = 0;

  always #5 clk = ~clk;

  cp_issue_front #(.OPC_W(OPC_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_opcode(push_opcode),
    .push_vec(push_vec), .push_len(push_len), .push_tag(push_tag),
    .q_full(q_full), .q_empty(q_empty), .can_accept(can_accept), .ex_ready(ex_ready),
    .len_hold(len_hold), .len_val(len_val), .len_tag(len_tag),
    .acc_hold(acc_hold), .acc_flag(acc_flag), .acc_tag(acc_tag),
    .ex_valid(ex_valid), .ex_opcode(ex_opcode), .ex_tag(ex_tag), .ex_phantom(ex_phantom)
  );

  function automatic int exp_len(item_t it);
    if (it.vec) return int'(it.len);
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check after settling, advance the model.
  task automatic cycle(bit pv, bit vec, int len, int tag, int opc, bit rdy, bit acc);
    bit e_len, e_acc, push_ok;
    item_t nw;
    @(negedge clk);
    push_valid = pv; push_vec = vec; push_len = LEN_W'(len);
    push_tag = TAG_W'(tag); push_opcode = OPC_W'(opc);
    ex_ready = rdy; can_accept = acc;
    #1;
    e_len = (mq.size() > 0) && (!m_iss_v || rdy);   // R11 refill when leaving
    e_acc = m_iss_v && rdy;
    chk(q_full == (mq.size() == DEPTH), "R3 q_full", int'(q_full), int'(mq.size() == DEPTH));
    chk(q_empty == (mq.size() == 0), "R2 q_empty", int'(q_empty), int'(mq.size() == 0));
    chk(len_hold == !e_len, "R6 len_hold", int'(len_hold), int'(!e_len));
    if (e_len && !len_hold) begin
      chk(len_tag == mq[0].tag, "R4 len_tag order", int'(len_tag), int'(mq[0].tag));
      chk(int'(len_val) == exp_len(mq[0]), "R5 len_val", int'(len_val), exp_len(mq[0]));
    end
    chk(acc_hold == !e_acc, "R8 R9 acc_hold", int'(acc_hold), int'(!e_acc));
    if (e_acc && !acc_hold) begin
      chk(acc_tag == m_iss.tag, "R7 acc_tag", int'(acc_tag), int'(m_iss.tag));
      chk(acc_flag == acc, "R7 acc_flag", int'(acc_flag), int'(acc));
    end
    chk(ex_valid == m_ex_v, "R10 ex_valid", int'(ex_valid), int'(m_ex_v));
    if (m_ex_v && ex_valid) begin
      chk(ex_tag == m_ex.tag, "R10 ex_tag", int'(ex_tag), int'(m_ex.tag));
      chk(ex_opcode == m_ex.opc, "R10 ex_opcode", int'(ex_opcode), int'(m_ex.opc));
      chk(ex_phantom == m_ex_ph, "R10 ex_phantom", int'(ex_phantom), int'(m_ex_ph));
    end
    push_ok = pv && (mq.size() < DEPTH);
    if (pv && !push_ok) ignored++;
    m_ex_v = e_acc;
    if (e_acc) begin
      m_ex = m_iss; m_ex_ph = !acc;
      if (!acc) phantoms++;
      m_iss_v = 0;
    end
    if (e_len) begin m_iss = mq.pop_front(); m_iss_v = 1; end
    if (push_ok) begin
      nw.opc = OPC_W'(opc); nw.vec = vec; nw.len = LEN_W'(len); nw.tag = TAG_W'(tag);
      mq.push_back(nw);
    end
  endtask

  initial begin
    void'($urandom(32'd1921));
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(q_empty == 1'b1, "R1 q_empty", int'(q_empty), 1);
    chk(q_full == 1'b0, "R1 q_full", int'(q_full), 0);
    chk(len_hold == 1'b1, "R1 len_hold", int'(len_hold), 1);
    chk(acc_hold == 1'b1, "R1 acc_hold", int'(acc_hold), 1);
    chk(ex_valid == 1'b0, "R1 ex_valid", int'(ex_valid), 0);
    rst_n = 1'b1;
    // R3 directed: stall execute and push six; one enters issue, four fill, one dropped
    for (int i = 1; i <= 6; i++) cycle(1, i[0], i + 2, i, 16 + i, 0, 1);
    cycle(0, 0, 0, 0, 0, 0, 1);  // R9 stall with full queue
    chk(ignored > 0, "R3 overflow push ignored", ignored, 1);
    // R8 directed: drain with alternating refusals
    for (int i = 0; i < 8; i++) cycle(0, 0, 0, 0, 0, 1, i[0]);
    // random mix
    for (int i = 0; i < N_RAND; i++)
      cycle(($urandom % 3) != 0, $urandom % 2, $urandom % 16, $urandom % 16,
            $urandom % 256, ($urandom % 4) != 0, ($urandom % 3) != 0);
    for (int i = 0; i < 10; i++) cycle(0, 0, 0, 0, 0, 1, 0);
    chk(phantoms > 0, "R10 phantoms produced", phantoms, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule